// File: doc/BRIEF.md
# Programmable Tick Timer

A 32-bit tick timer built from a control word and a free-running count. The control word carries a 28-bit period, a sticky pending flag, an interrupt enable and a 2-bit mode. While the timer runs, the count advances by one each clock. When the low 28 bits of the count equal the period, the pending flag is set. What the count does next depends on the mode: it returns to zero, it freezes, or it carries on.

Software reaches the block through a single write strobe with a one-bit select that picks the control word or the count. Both registers are visible at all times for reads, and the count output is always the live value. Counting is started and stopped only by a write that changes the mode field. Rewriting the mode it already holds leaves the running state alone, so a timer that has stopped in single-shot mode stays stopped until its mode is changed.

Top module: `tick_timer`

## Requirements
- R1: A synchronous reset clears the control word and the count to zero, stops counting and drops the interrupt output.
- R2: A write with `wr_sel`=0 stores the control word. Period is bits 27:0, the pending flag is bit 28, interrupt enable is bit 29 and the mode is bits 31:30. The modes are 00 off, 01 restart, 10 single-shot and 11 interrupt-only. `ctrl_o` returns the stored word.
- R3: In a control write, a 1 in bit 28 keeps the pending flag at its current value and a 0 clears it. Otherwise the flag stays set once it is set.
- R4: Counting starts or stops only on a control write whose mode differs from the stored mode: running after a change to 01, 10 or 11, stopped after a change to 00. A write of the same mode leaves the running state unchanged.
- R5: A write with `wr_sel`=1 loads the count directly. While running, the count rises by one per clock, and `count_o` always shows the live value.
- R6: In restart mode (01), a match sets the pending flag and the count is 0 on the next cycle.
- R7: In single-shot mode (10), a match sets the pending flag, the count holds at its value and counting stops.
- R8: In interrupt-only mode (11), a match sets the pending flag and the count keeps incrementing.
- R9: While stopped, the count does not change and no match is evaluated, even after a count load that equals the period.
- R10: `irq_o` is high exactly when both the pending flag and the interrupt enable are set.
- R11: The match compares only the low 28 bits of the count with the period. The upper 4 count bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | 0 selects the control word, 1 selects the count |
| wr_data | input | 32 | Write data |
| ctrl_o | output | 32 | Stored control word |
| count_o | output | 32 | Live count |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a single-shot timer that has stopped by itself while its mode field still reads single-shot. Only a rewrite of that same mode shows that starting depends on a change of mode. The stimulus clears the count, switches from off to single-shot with a short period, waits past the match, and then rewrites mode 10 and checks that the count stays frozen. Separate stimulus loads a count whose upper bits are set under interrupt-only mode, to show the match ignores them. Another loads a count equal to the period while the timer is off, to show no match fires while stopped.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

   typedef enum logic [1:0] {
      TM_OFF     = 2'b00,
      TM_RESTART = 2'b01,
      TM_SINGLE  = 2'b10,
      TM_INTONLY = 2'b11
   } tmode_e;

endpackage

// File: rtl/tt_ctrl_reg.sv
module tt_ctrl_reg
   import tick_timer_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int PERIOD_W = 28
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                wr,
   input  logic [DATA_W-1:0]   wd,
   input  logic                hit,
   input  logic                stop_req,
   output logic [PERIOD_W-1:0] period,
   output logic                pend,
   output logic                ie,
   output tmode_e              mode,
   output logic                run
);

   localparam int P_PEND = PERIOD_W;
   localparam int P_IE   = PERIOD_W + 1;
   localparam int P_MLO  = PERIOD_W + 2;

   tmode_e wr_mode;
   logic   mode_change;

   assign wr_mode     = tmode_e'(wd[P_MLO+1:P_MLO]);
   assign mode_change = wr && (wr_mode != mode);

   always_ff @(posedge clk) begin
      if (rst) begin
         period <= '0;
         pend   <= 1'b0;
         ie     <= 1'b0;
         mode   <= TM_OFF;
         run    <= 1'b0;
      end else begin
         if (wr) begin
            period <= wd[PERIOD_W-1:0];
            ie     <= wd[P_IE];
            mode   <= wr_mode;
            pend   <= wd[P_PEND] ? (pend | hit) : 1'b0;
         end else if (hit) begin
            pend <= 1'b1;
         end
         if (mode_change)
            run <= (wr_mode != TM_OFF);
         else if (stop_req)
            run <= 1'b0;
      end
   end

   // R3: the flag stays set unless a write carries a 0 in the pending bit
   p_pend_sticky_r3: assert property (@(posedge clk) disable iff (rst)
      ((pend || hit) && !(wr && !wd[P_PEND])) |=> pend);

   p_pend_clear_r3: assert property (@(posedge clk) disable iff (rst)
      (wr && !wd[P_PEND]) |=> !pend);

   p_run_mode_r4: assert property (@(posedge clk) disable iff (rst)
      run |-> (mode != TM_OFF));

   p_run_hold_r4: assert property (@(posedge clk) disable iff (rst)
      (!mode_change && !stop_req) |=> $stable(run));

endmodule

// File: rtl/tt_counter.sv
module tt_counter
   import tick_timer_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int PERIOD_W = 28
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                run,
   input  tmode_e              mode,
   input  logic [PERIOD_W-1:0] period,
   input  logic                ld,
   input  logic [DATA_W-1:0]   ld_data,
   output logic [DATA_W-1:0]   cnt,
   output logic                hit,
   output logic                stop_req
);

   logic [DATA_W-1:0] cnt_nxt;

   assign hit      = run && (cnt[PERIOD_W-1:0] == period);
   assign stop_req = hit && (mode == TM_SINGLE);

   always_comb begin
      cnt_nxt = cnt;
      if (ld) begin
         cnt_nxt = ld_data;
      end else if (run) begin
         if (hit && mode == TM_RESTART)
            cnt_nxt = '0;
         else if (hit && mode == TM_SINGLE)
            cnt_nxt = cnt;
         else
            cnt_nxt = cnt + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) cnt <= '0;
      else     cnt <= cnt_nxt;
   end

   p_restart_r6: assert property (@(posedge clk) disable iff (rst)
      (hit && mode == TM_RESTART && !ld) |=> (cnt == '0));

   p_single_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (hit && mode == TM_SINGLE && !ld) |=> $stable(cnt));

   p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
      (!run && !ld) |=> $stable(cnt));

   p_step_r5: assert property (@(posedge clk) disable iff (rst)
      (run && !hit && !ld) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/tick_timer.sv
module tick_timer
   import tick_timer_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int PERIOD_W = 28
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] ctrl_o,
   output logic [DATA_W-1:0] count_o,
   output logic              irq_o
);

   localparam int CTRL_BITS = PERIOD_W + 4;

   initial begin
      assert (CTRL_BITS == DATA_W)
         else $error("tick_timer: period width plus 4 must equal data width");
      assert (PERIOD_W >= 1)
         else $error("tick_timer: period width must be positive");
   end

   logic [PERIOD_W-1:0] period;
   logic                pend, ie, run, hit, stop_req;
   tmode_e              mode;
   logic                wr_ctrl, wr_cnt;

   assign wr_ctrl = wr_en && !wr_sel;
   assign wr_cnt  = wr_en &&  wr_sel;

   tt_ctrl_reg #(.DATA_W(DATA_W), .PERIOD_W(PERIOD_W)) u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .wr       (wr_ctrl),
      .wd       (wr_data),
      .hit      (hit),
      .stop_req (stop_req),
      .period   (period),
      .pend     (pend),
      .ie       (ie),
      .mode     (mode),
      .run      (run)
   );

   tt_counter #(.DATA_W(DATA_W), .PERIOD_W(PERIOD_W)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .run      (run),
      .mode     (mode),
      .period   (period),
      .ld       (wr_cnt),
      .ld_data  (wr_data),
      .cnt      (count_o),
      .hit      (hit),
      .stop_req (stop_req)
   );

   assign ctrl_o = {mode, ie, pend, period};
   assign irq_o  = pend & ie;

   // R1: the cycle after reset everything reads zero
   p_reset_r1: assert property (@(posedge clk)
      rst |=> (ctrl_o == '0 && count_o == '0 && !irq_o));

   p_match_sets_r11: assert property (@(posedge clk) disable iff (rst)
      (hit && !wr_ctrl) |=> pend);

endmodule

// File: tb/tick_timer_test.sv
module tick_timer_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic        wr_sel = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] ctrl_o, count_o;
   logic        irq_o;

   int n_chk  = 0;
   int n_fail = 0;
   int cycles = 0;
   string cur_req = "R1";

   // reference state
   bit [31:0] m_ctrl = 0;
   bit [31:0] m_cnt  = 0;
   bit        m_run  = 0;

   always #4 clk = ~clk;   // 125 MHz

   tick_timer uut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .ctrl_o(ctrl_o), .count_o(count_o), .irq_o(irq_o)
   );

   // behavioural reference, updated on each rising edge
   always @(posedge clk) begin
      bit [1:0]  md, nmd;
      bit        hit, pend, ie;
      bit [31:0] nctrl, ncnt;
      bit        nrun;
      md    = m_ctrl[31:30];
      pend  = m_ctrl[28];
      hit   = m_run && (m_cnt[27:0] == m_ctrl[27:0]);
      nctrl = m_ctrl;
      ncnt  = m_cnt;
      nrun  = m_run;
      if (rst) begin
         nctrl = 0; ncnt = 0; nrun = 0;
      end else begin
         if (wr_en && !wr_sel) begin
            nmd   = wr_data[31:30];
            nctrl = wr_data;
            nctrl[28] = wr_data[28] ? (pend | hit) : 1'b0;
            if (nmd != md) nrun = (nmd != 2'b00);
            else if (hit && md == 2'b10) nrun = 0;
         end else begin
            if (hit) nctrl[28] = 1'b1;
            if (hit && md == 2'b10) nrun = 0;
         end
         if (wr_en && wr_sel) ncnt = wr_data;
         else if (m_run) begin
            if (hit && md == 2'b01)      ncnt = 0;
            else if (hit && md == 2'b10) ncnt = m_cnt;
            else                         ncnt = m_cnt + 1;
         end
      end
      ie     = nctrl[29];
      m_ctrl = nctrl;
      m_cnt  = ncnt;
      m_run  = nrun;
      cycles = cycles + 1;
   end

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %08h expected %08h at %0t", req, act, exp, $time);
      end
   endtask

   // compare against the reference on every falling edge
   always @(negedge clk) begin
      if (!rst) begin
         check(cur_req, ctrl_o, m_ctrl);
         check(cur_req, count_o, m_cnt);
         check({cur_req, " R10"}, {31'd0, irq_o}, {31'd0, m_ctrl[28] & m_ctrl[29]});
      end
   end

   task automatic wr(bit sel, bit [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
   endtask

   function automatic bit [31:0] cw(bit [1:0] md, bit ie, bit pd, bit [27:0] per);
      return {md, ie, pd, per};
   endfunction

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      bit [31:0] snap;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check("R1", ctrl_o, 32'd0);
      check("R1", count_o, 32'd0);
      check("R1", {31'd0, irq_o}, 32'd0);

      cur_req = "R9";
      wr(1'b1, 32'd7);
      wr(1'b0, cw(2'b00, 1'b1, 1'b1, 28'd7));
      idle(5);
      check("R9", count_o, 32'd7);
      check("R9", {31'd0, ctrl_o[28]}, 32'd0);
      check("R2", ctrl_o, cw(2'b00, 1'b1, 1'b0, 28'd7));

      cur_req = "R6";
      wr(1'b1, 32'd0);
      wr(1'b0, cw(2'b01, 1'b1, 1'b1, 28'd4));
      idle(20);
      check("R10", {31'd0, irq_o}, 32'd1);
      check("R6", {31'd0, (count_o <= 32'd4)}, 32'd1);

      cur_req = "R3";
      wr(1'b0, cw(2'b01, 1'b1, 1'b1, 28'd4));
      check("R3", {31'd0, ctrl_o[28]}, 32'd1);
      wr(1'b0, cw(2'b01, 1'b1, 1'b0, 28'd4));
      check("R3", {31'd0, ctrl_o[28]}, 32'd0);

      cur_req = "R10";
      wr(1'b0, cw(2'b01, 1'b0, 1'b1, 28'd4));
      idle(8);
      check("R10", {31'd0, ctrl_o[28]}, 32'd1);
      check("R10", {31'd0, irq_o}, 32'd0);

      cur_req = "R5";
      wr(1'b0, cw(2'b01, 1'b0, 1'b0, 28'd100));
      wr(1'b1, 32'd50);
      idle(3);
      check("R5", count_o, 32'd53);

      cur_req = "R7";
      wr(1'b0, cw(2'b00, 1'b1, 1'b0, 28'd6));
      wr(1'b1, 32'd0);
      wr(1'b0, cw(2'b10, 1'b1, 1'b0, 28'd6));
      idle(15);
      check("R7", count_o, 32'd6);
      check("R7", {31'd0, irq_o}, 32'd1);
      cur_req = "R4";
      wr(1'b0, cw(2'b10, 1'b1, 1'b1, 28'd6));
      idle(6);
      check("R4", count_o, 32'd6);

      cur_req = "R11";
      wr(1'b0, cw(2'b00, 1'b1, 1'b0, 28'd3));
      wr(1'b1, 32'h3000_0000);
      wr(1'b0, cw(2'b11, 1'b1, 1'b0, 28'd3));
      idle(10);
      check("R11", {31'd0, irq_o}, 32'd1);
      cur_req = "R8";
      check("R8", {31'd0, (count_o > 32'h3000_0003)}, 32'd1);

      cur_req = "R4";
      wr(1'b0, cw(2'b00, 1'b1, 1'b1, 28'd3));
      snap = count_o;
      idle(5);
      check("R4", count_o, snap);

      cur_req = "R1";
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      check("R1", ctrl_o, 32'd0);
      check("R1", count_o, 32'd0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   // watchdog
   initial begin
      #400000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule